// File: doc/BRIEF.md
# Serial Frame Transmitter with Completion Flag

This block drives an asynchronous serial line. It sends three kinds of frame. A data frame is a low start bit, then 8 data bits (9 when the long-word mode input is high) sent least significant bit first, then a high stop bit. An idle preamble is a whole frame time of high bits. A break is a whole frame time of low bits followed by one high stop bit. Software loads a word into a one-entry holding register with a write strobe. The word moves into the shift engine at the next frame boundary, and preamble and break requests are queued by single-cycle pulses. An external baud tick paces each bit.

Two flags are kept. The empty flag shows that the holding register can take a new word. The completion flag shows that the line has gone quiet. When the transmitter is enabled, that means nothing is left to send. When it is disabled, that means the frame in flight has ended. Software clears the completion flag with a status read that sees it set, followed by a data write. The flag also clears whenever the empty flag falls. The flag is only reported and never steers the transmitter.

Top module: `tfx_serial_tx`

## Requirements
- R1: While reset is asserted, and after it is released, `txd` is 1 whenever no frame is in flight. `empty_flag` reads 1 and `done_flag` reads 0 during reset.
- R2: A data frame in short mode (`long_mode`=0) lasts 10 baud periods: a 0, then `data_in[0]` through `data_in[7]`, then a 1. Each bit occupies the interval from one baud tick to the next.
- R3: With `long_mode`=1, a data frame carries `data_in[8]` after `data_in[7]`, and the frame lasts 11 periods.
- R4: A queued preamble holds the line at 1 for one frame length (10 or 11 periods, set by `long_mode`).
- R5: A queued break holds the line at 0 for one frame length and then sends a single 1, so it lasts 11 or 12 periods.
- R6: At a frame boundary with several items waiting, a break goes first, then a preamble, then the held data word. Successive frames follow with no idle period between them.
- R7: A data write drops `empty_flag` in the next cycle. When the shift engine takes the word, `empty_flag` returns to 1.
- R8: With `tx_en`=1, `done_flag` sets once the holding register is empty, no frame is in flight and no preamble or break is pending. It stays 0 while a frame is shifting out after a clear.
- R9: When `tx_en` drops during a frame, that frame still completes and `done_flag` then sets. No new frame starts while `tx_en`=0, even if a word is held.
- R10: A `stat_rd` pulse while `done_flag`=1 arms a clear, and the next data write clears `done_flag`. A data write with no such prior read, made while `empty_flag` is already 0, leaves `done_flag` at 1.
- R11: A data write while `empty_flag`=1 clears `done_flag`.
- R12: A held word is sent normally when transmission starts while `done_flag`=1, and `done_flag` keeps its value during that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| long_mode | input | 1 | 1 selects 9-bit data words, 0 selects 8-bit |
| data_wr | input | 1 | Holding register write strobe |
| data_in | input | 9 | Word to load; bit 8 is used only in long mode |
| stat_rd | input | 1 | Status register read strobe |
| queue_pre | input | 1 | Pulse to queue an idle preamble |
| queue_brk | input | 1 | Pulse to queue a break |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| txd | output | 1 | Serial line |
| empty_flag | output | 1 | Holding register empty |
| done_flag | output | 1 | Transmission complete |

## Verification
The bench queues a break, a preamble and a data word while another frame is on the line. A design with the wrong priority, or one that inserts an idle gap, would put the bits in the wrong order. It drops the enable partway through a frame. A design that aborts the frame would cut the bit stream short, and one that waits for an empty register would never raise the completion flag. It overwrites a held word with and without a preceding status read. A design that ignores the arm would keep the flag set, and one that clears on any write would drop it. Long-word, preamble and break lengths are compared bit by bit, so an off-by-one frame length shows up as a shifted stream.

// File: rtl/tfx_pkg.sv
package tfx_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_DATA = 2'd1,
    KIND_PRE  = 2'd2,
    KIND_BRK  = 2'd3
  } kind_e;
endpackage

// File: rtl/tfx_holding.sv
module tfx_holding
  import tfx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            data_wr,
  input  logic [DATA_W:0] data_in,
  input  logic            queue_pre,
  input  logic            queue_brk,
  input  kind_e           take,
  output logic [DATA_W:0] hold_q,
  output logic            empty_q,
  output logic            pend_pre_q,
  output logic            pend_brk_q,
  output logic            empty_fall
);
  logic [DATA_W:0] hold_d;
  logic            empty_d, pre_d, brk_d;

  always_comb begin
    hold_d  = hold_q;
    empty_d = empty_q;
    if (take == KIND_DATA) empty_d = 1'b1;
    if (data_wr) begin
      hold_d  = data_in;
      empty_d = 1'b0;
    end
    pre_d      = (pend_pre_q && take != KIND_PRE) || queue_pre;
    brk_d      = (pend_brk_q && take != KIND_BRK) || queue_brk;
    empty_fall = data_wr && empty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      empty_q    <= 1'b1;
      pend_pre_q <= 1'b0;
      pend_brk_q <= 1'b0;
    end else begin
      hold_q     <= hold_d;
      empty_q    <= empty_d;
      pend_pre_q <= pre_d;
      pend_brk_q <= brk_d;
    end
  end

  p_write_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !empty_q);
  p_take_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take == KIND_DATA && !data_wr) |=> empty_q);
endmodule

// File: rtl/tfx_shifter.sv
module tfx_shifter
  import tfx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic            long_mode,
  input  logic            baud_tick,
  input  logic [DATA_W:0] hold_q,
  input  logic            empty_q,
  input  logic            pend_pre_q,
  input  logic            pend_brk_q,
  output kind_e           take,
  output logic            busy_q,
  output logic            frame_end,
  output logic            txd
);
  localparam int SHORT_LEN = DATA_W + 2;
  localparam int LONG_LEN  = DATA_W + 3;
  localparam int SR_W      = LONG_LEN + 1;
  localparam int CNT_W     = $clog2(SR_W + 1);

  logic [SR_W-1:0]  sr_q, sr_d, frame_vec;
  logic [CNT_W-1:0] cnt_q, cnt_d, frame_len;
  logic             busy_d, last_bit;

  always_comb begin
    last_bit  = busy_q && (cnt_q == CNT_W'(1));
    frame_end = baud_tick && last_bit;
    take      = KIND_NONE;
    if (baud_tick && tx_en && (!busy_q || last_bit)) begin
      if (pend_brk_q)      take = KIND_BRK;
      else if (pend_pre_q) take = KIND_PRE;
      else if (!empty_q)   take = KIND_DATA;
    end
    frame_len = long_mode ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
    frame_vec = '1;
    if (take == KIND_DATA) begin
      frame_vec[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) frame_vec[i+1] = hold_q[i];
      if (long_mode) frame_vec[DATA_W+1] = hold_q[DATA_W];
    end else if (take == KIND_BRK) begin
      for (int i = 0; i < SR_W; i++) frame_vec[i] = (CNT_W'(i) >= frame_len);
    end
  end

  always_comb begin
    busy_d = busy_q;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    if (take != KIND_NONE) begin
      busy_d = 1'b1;
      sr_d   = frame_vec;
      cnt_d  = (take == KIND_BRK) ? frame_len + CNT_W'(1) : frame_len;
    end else if (baud_tick && busy_q) begin
      if (last_bit) begin
        busy_d = 1'b0;
      end else begin
        sr_d  = {1'b1, sr_q[SR_W-1:1]};
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sr_q   <= '1;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign txd = !busy_q || sr_q[0];

  p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd);
  p_no_start_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !tx_en) |=> !busy_q);
  p_bit_held_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> ($stable(sr_q) && $stable(busy_q)));
  p_break_starts_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take == KIND_BRK) |=> !txd);
endmodule

// File: rtl/tfx_done_flag.sv
module tfx_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic empty_q,
  input  logic busy_q,
  input  logic pend_any,
  input  logic frame_end,
  input  logic data_wr,
  input  logic empty_fall,
  input  logic stat_rd,
  output logic tc_q
);
  logic armed_q, armed_d, tc_d, clr, set;

  always_comb begin
    clr = empty_fall || (data_wr && armed_q);
    set = (tx_en && empty_q && !busy_q && !pend_any) || (!tx_en && frame_end);
    if (data_wr)              armed_d = 1'b0;
    else if (stat_rd && tc_q) armed_d = 1'b1;
    else                      armed_d = armed_q;
    if (clr)      tc_d = 1'b0;
    else if (set) tc_d = 1'b1;
    else          tc_d = tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      tc_q    <= tc_d;
    end
  end

  p_empty_fall_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    empty_fall |=> !tc_q);
  p_armed_write_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && armed_q) |=> !tc_q);
  p_off_end_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && frame_end && !data_wr) |=> tc_q);
endmodule

// File: rtl/tfx_serial_tx.sv
module tfx_serial_tx
  import tfx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_en,
  input  logic            long_mode,
  input  logic            data_wr,
  input  logic [DATA_W:0] data_in,
  input  logic            stat_rd,
  input  logic            queue_pre,
  input  logic            queue_brk,
  input  logic            baud_tick,
  output logic            txd,
  output logic            empty_flag,
  output logic            done_flag
);
  kind_e           take;
  logic [DATA_W:0] hold_q;
  logic            empty_q, pend_pre_q, pend_brk_q, empty_fall;
  logic            busy_q, frame_end;

  tfx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_wr    (data_wr),
    .data_in    (data_in),
    .queue_pre  (queue_pre),
    .queue_brk  (queue_brk),
    .take       (take),
    .hold_q     (hold_q),
    .empty_q    (empty_q),
    .pend_pre_q (pend_pre_q),
    .pend_brk_q (pend_brk_q),
    .empty_fall (empty_fall)
  );

  tfx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .long_mode  (long_mode),
    .baud_tick  (baud_tick),
    .hold_q     (hold_q),
    .empty_q    (empty_q),
    .pend_pre_q (pend_pre_q),
    .pend_brk_q (pend_brk_q),
    .take       (take),
    .busy_q     (busy_q),
    .frame_end  (frame_end),
    .txd        (txd)
  );

  tfx_done_flag u_done (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .empty_q    (empty_q),
    .busy_q     (busy_q),
    .pend_any   (pend_pre_q || pend_brk_q),
    .frame_end  (frame_end),
    .data_wr    (data_wr),
    .empty_fall (empty_fall),
    .stat_rd    (stat_rd),
    .tc_q       (done_flag)
  );

  assign empty_flag = empty_q;
endmodule

// File: tb/tfx_serial_tx_tb.sv
module tfx_serial_tx_tb;
  logic       clk, rst_n, tx_en, long_mode, data_wr, stat_rd;
  logic       queue_pre, queue_brk, baud_tick;
  logic [8:0] data_in;
  logic       txd, empty_flag, done_flag;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 0;
  bit    exp_q[$];
  string req_q[$];

  tfx_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .long_mode(long_mode),
    .data_wr(data_wr), .data_in(data_in), .stat_rd(stat_rd),
    .queue_pre(queue_pre), .queue_brk(queue_brk), .baud_tick(baud_tick),
    .txd(txd), .empty_flag(empty_flag), .done_flag(done_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    baud_tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: one expected line bit per baud period, popped after each tick.
  initial begin
    forever begin
      @(posedge clk);
      if (baud_tick) begin
        @(negedge clk);
        if (exp_q.size() != 0) begin
          automatic bit    e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          chk(r, txd, e);
        end
      end
    end
  end

  task automatic push_bit(input bit b, input string req);
    exp_q.push_back(b);
    req_q.push_back(req);
  endtask

  task automatic push_data(input logic [8:0] d, input bit nine);
    push_bit(1'b0, "R2 start");
    for (int i = 0; i < 8; i++) push_bit(d[i], nine ? "R3 data" : "R2 data");
    if (nine) push_bit(d[8], "R3 ninth bit");
    push_bit(1'b1, nine ? "R3 stop" : "R2 stop");
  endtask

  task automatic push_ones(input int n);
    for (int i = 0; i < n; i++) push_bit(1'b1, "R4 preamble");
  endtask

  task automatic push_break(input int n);
    for (int i = 0; i < n; i++) push_bit(1'b0, "R5 break low");
    push_bit(1'b1, "R5 break stop");
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!baud_tick);
    end
    @(negedge clk);
  endtask

  task automatic sync_slot();
    wait_ticks(1);
    @(negedge clk);
  endtask

  task automatic write_word(input logic [8:0] d);
    data_in = d;
    data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic pulse_pre();
    queue_pre = 1'b1; @(negedge clk); queue_pre = 1'b0;
  endtask

  task automatic pulse_brk();
    queue_brk = 1'b1; @(negedge clk); queue_brk = 1'b0;
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    wait_ticks(2);
  endtask

  // Leaves the transmitter disabled with done_flag=1 and a word held.
  task automatic prep_held(input logic [8:0] d_run, input logic [8:0] d_held);
    sync_slot();
    write_word(d_run);
    push_data(d_run, 1'b0);
    wait_ticks(3);
    tx_en = 1'b0;
    write_word(d_held);
    chk("R9 flag low mid-frame", done_flag, 1'b0);
    drain();
    chk("R9 flag after disabled frame", done_flag, 1'b1);
    chk("R9 word still held", empty_flag, 1'b0);
    for (int i = 0; i < 4; i++) begin
      wait_ticks(1);
      chk("R9 no start while disabled", txd, 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b1; long_mode = 1'b0; data_wr = 1'b0;
    stat_rd = 1'b0; queue_pre = 1'b0; queue_brk = 1'b0; data_in = '0;
    repeat (3) @(negedge clk);
    chk("R1 txd in reset", txd, 1'b1);
    chk("R1 empty in reset", empty_flag, 1'b1);
    chk("R1 done in reset", done_flag, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 done after idle", done_flag, 1'b1);
    chk("R1 line idle", txd, 1'b1);

    // Plain 8-bit word; write with empty=1 clears done (R11).
    sync_slot();
    write_word(9'h0A5);
    push_data(9'h0A5, 1'b0);
    chk("R7 empty drops on write", empty_flag, 1'b0);
    chk("R11 done cleared by write", done_flag, 1'b0);
    wait_ticks(3);
    chk("R7 empty after transfer", empty_flag, 1'b1);
    chk("R8 done low while shifting", done_flag, 1'b0);
    drain();
    chk("R8 done after frame", done_flag, 1'b1);

    // 9-bit word.
    long_mode = 1'b1;
    sync_slot();
    write_word(9'h1C3);
    push_data(9'h1C3, 1'b1);
    drain();

    // Preamble then data, short mode.
    long_mode = 1'b0;
    sync_slot();
    pulse_pre();
    write_word(9'h03C);
    push_ones(10);
    push_data(9'h03C, 1'b0);
    drain();

    // Break in long mode.
    long_mode = 1'b1;
    sync_slot();
    pulse_brk();
    push_break(11);
    drain();

    // Priority at boundary: break, preamble, data, back to back (R6).
    long_mode = 1'b0;
    sync_slot();
    write_word(9'h055);
    push_data(9'h055, 1'b0);
    wait_ticks(2);
    write_word(9'h00F);
    pulse_pre();
    pulse_brk();
    push_break(10);
    push_ones(10);
    push_data(9'h00F, 1'b0);
    drain();
    chk("R6 done after sequence", done_flag, 1'b1);

    // Unarmed overwrite keeps done; held word sent with done=1 (R10, R12).
    prep_held(9'h081, 9'h07E);
    write_word(9'h011);
    chk("R10 unarmed write keeps done", done_flag, 1'b1);
    sync_slot();
    tx_en = 1'b1;
    push_data(9'h011, 1'b0);
    wait_ticks(3);
    chk("R12 done kept while sending", done_flag, 1'b1);
    drain();

    // Armed clear (R10).
    prep_held(9'h096, 9'h044);
    pulse_rd();
    write_word(9'h022);
    chk("R10 armed write clears done", done_flag, 1'b0);
    sync_slot();
    tx_en = 1'b1;
    push_data(9'h022, 1'b0);
    drain();
    chk("R8 done after last frame", done_flag, 1'b1);
    chk("R1 line idle at end", txd, 1'b1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule